// File: doc/BRIEF.md
# AES Round-Key Expansion Unit (128/192/256-bit)

This unit turns an AES cipher key of 128, 192 or 256 bits into the full round-key schedule. It produces one 32-bit word per clock and writes each word to a key-store write port at addresses that count up from zero. The key arrives as 32-bit words on `key_word`. A 2-bit control `key_ctl` starts an expansion and selects the key size. After the start cycle, the remaining key words follow on the next consecutive cycles.

A single datapath serves all three sizes. The last eight generated words sit in a shift register. The XOR partner for a new word is tapped from that history at a depth set by the key size. The transform applied to the newest word is either a rotate, byte-substitute and round-constant step, a substitute-only step (256-bit keys only), or no transform. Position counters pick the transform and step the round constant. The substitution box is computed from its field definition rather than stored as a table.

Top module: `aes_key_expander`

## Requirements
- R1: While reset is active, and in the first cycle after it, `wr_en`, `busy` and `done` are low.
- R2: While idle, `key_ctl` = 00 is a message code and starts nothing. Codes 01, 10 and 11 start an expansion with Nk = 4, 6 or 8 key words. The `key_word` value present in the start cycle is key word 0, and key word k is presented k cycles after the start.
- R3: Words 0 to Nk-1 are written unchanged from the key input. Word 0 appears on the port in the cycle after the start, and one word follows per cycle.
- R4: For a word index i ≥ Nk that is a multiple of Nk, the word is w[i-Nk] XOR SubWord(RotWord(w[i-1])) XOR (rcon << 24).
- R5: For 256-bit keys, when i mod 8 = 4, the word is w[i-8] XOR SubWord(w[i-1]). No rotation and no round constant are applied.
- R6: Every other word with i ≥ Nk is w[i-Nk] XOR w[i-1].
- R7: The round constant is 0x01 for the first multiple-of-Nk word. After each use it is multiplied by 2 in GF(2^8) and reduced with 0x1B.
- R8: Exactly 44, 52 or 60 words are written for 128-, 192- and 256-bit keys. They are written on consecutive cycles at addresses 0, 1, 2, and so on, with `busy` high throughout.
- R9: `done` is high for exactly one cycle, in the cycle after the last write. In that cycle `busy` and `wr_en` are low.
- R10: A nonzero `key_ctl`, and any `key_word` value, presented while busy after the key words have been taken, has no effect on the written words or on their count.
- R11: Byte 0 of a word sits in bits 31:24. RotWord moves bits 31:24 down to bits 7:0. The round constant is XORed into bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_ctl | input | 2 | 00 message, 01 128-bit key, 10 192-bit key, 11 256-bit key |
| key_word | input | 32 | Cipher key word input |
| wr_en | output | 1 | Key-store write strobe |
| wr_addr | output | ADDR_W | Key-store write address |
| wr_data | output | 32 | Round-key word |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
Each of the three key sizes is expanded from four keys: all zeros, all ones, incrementing bytes, and a pseudo-random pattern. Every word is compared against a schedule that the bench computes with its own logarithm-based substitution box. The all-zero key separates the Rcon and substitution path from plain XOR chaining. The incrementing key exposes any byte-order or rotation error. The 256-bit runs exercise the substitute-only step that the other sizes never take. Junk control codes and data are driven during generation and while idle, to show that a restart while busy and a message code are both ignored.

// File: rtl/aes_key_expander.sv
module aes_key_expander #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        key_ctl,
  input  logic [31:0]       key_word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done
);

  localparam int HIST = 8;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, p;
    r = 8'h00;
    p = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r = r ^ p;
      p = xt(p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] r, sq, b;
    r  = 8'h01;
    sq = x;
    for (int k = 0; k < 8; k++) begin
      if (k != 0) r = gmul(r, sq);
      sq = gmul(sq, sq);
    end
    b = r;
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  logic [1:0]        size_r;
  logic [31:0]       hist [HIST];
  logic [ADDR_W-1:0] idx;
  logic [2:0]        pos;
  logic [7:0]        rcon;

  logic [3:0]        nk;
  logic [ADDR_W-1:0] nw;
  logic              loading, start, wide;
  logic [31:0]       prev, partner, sub_in, sw, tmp, nxt;

  assign nk      = (size_r == 2'b01) ? 4'd4 : (size_r == 2'b10) ? 4'd6 : 4'd8;
  assign nw      = ADDR_W'(4 * (int'(nk) + 7));
  assign loading = idx < ADDR_W'(nk);
  assign start   = !busy && (key_ctl != 2'b00);
  assign wide    = (size_r == 2'b11);

  assign prev    = hist[0];
  assign partner = (size_r == 2'b01) ? hist[3] : (size_r == 2'b10) ? hist[5] : hist[7];
  assign sub_in  = (pos == 3'd0) ? {prev[23:0], prev[31:24]} : prev;
  assign sw      = subw(sub_in);
  assign tmp     = (pos == 3'd0)          ? (sw ^ {rcon, 24'h0}) :
                   (wide && pos == 3'd4)  ? sw : prev;
  assign nxt     = loading ? key_word : (partner ^ tmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_r  <= 2'b01;
      for (int k = 0; k < HIST; k++) hist[k] <= '0;
      idx     <= '0;
      pos     <= '0;
      rcon    <= 8'h01;
      busy    <= 1'b0;
      done    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (start) begin
      size_r  <= key_ctl;
      hist[0] <= key_word;
      for (int k = 1; k < HIST; k++) hist[k] <= hist[k-1];
      idx     <= ADDR_W'(1);
      pos     <= 3'd1;
      rcon    <= 8'h01;
      busy    <= 1'b1;
      done    <= 1'b0;
      wr_en   <= 1'b1;
      wr_addr <= '0;
      wr_data <= key_word;
    end else if (busy) begin
      if (idx == nw) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        wr_en <= 1'b0;
      end else begin
        hist[0] <= nxt;
        for (int k = 1; k < HIST; k++) hist[k] <= hist[k-1];
        wr_en   <= 1'b1;
        wr_addr <= idx;
        wr_data <= nxt;
        idx     <= idx + ADDR_W'(1);
        pos     <= ({1'b0, pos} == nk - 4'd1) ? 3'd0 : pos + 3'd1;
        if (!loading && pos == 3'd0) rcon <= xt(rcon);
      end
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
    end
  end

endmodule

module aes_key_expander_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              done
);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && !wr_en && !busy));

  // R3
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> (wr_addr == '0));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |-> ($past(wr_en) && wr_addr == $past(wr_addr) + 1'b1));

  // R8
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!wr_en && !busy && !done));

endmodule

bind aes_key_expander aes_key_expander_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .busy(busy), .done(done)
);

// File: tb/test_aes_key_expander.sv
module test_aes_key_expander;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        key_ctl = 2'b00;
  logic [31:0]       key_word = '0;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic              busy;
  logic              done;

  int checks = 0;
  int fails = 0;

  logic [7:0]  exp_t [256];
  logic [7:0]  log_t [256];
  logic [7:0]  sb    [256];
  logic [31:0] w     [60];
  logic [31:0] key   [8];
  logic [31:0] lfsr = 32'hace1_2468;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_key_expander #(.ADDR_W(ADDR_W)) i_aes_key_expander (
    .clk(clk), .rst_n(rst_n), .key_ctl(key_ctl), .key_word(key_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [31:0] sw4(input logic [31:0] v);
    return {sb[v[31:24]], sb[v[23:16]], sb[v[15:8]], sb[v[7:0]]};
  endfunction

  task automatic build_sbox();
    logic [7:0] e, inv, b;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = e;
      log_t[e] = 8'(i);
      e = e ^ dbl(e);
    end
    for (int x = 0; x < 256; x++) begin
      inv = (x == 0) ? 8'h00 : exp_t[(255 - int'(log_t[x])) % 255];
      b = inv;
      sb[x] = b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
    end
  endtask

  task automatic expand(input int nk, input int nw);
    logic [7:0]  rc;
    logic [31:0] t;
    rc = 8'h01;
    for (int i = 0; i < nw; i++) begin
      if (i < nk) w[i] = key[i];
      else begin
        t = w[i-1];
        if (i % nk == 0) begin
          t = sw4({t[23:0], t[31:24]}) ^ {rc, 24'h0};
          rc = dbl(rc);
        end else if (nk == 8 && i % 8 == 4) t = sw4(t);
        w[i] = w[i-nk] ^ t;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic string tag(input int i, input int nk);
    if (i < nk) return "R3";
    if (i % nk == 0) return "R4/R7/R11";
    if (nk == 8 && i % 8 == 4) return "R5";
    return "R6";
  endfunction

  task automatic run_key(input logic [1:0] sz, input int pat);
    int nk, nw;
    nk = (sz == 2'b01) ? 4 : (sz == 2'b10) ? 6 : 8;
    nw = 4 * (nk + 7);
    for (int k = 0; k < 8; k++) begin
      case (pat)
        0: key[k] = 32'h0;
        1: key[k] = 32'hffff_ffff;
        2: key[k] = {8'(4*k), 8'(4*k+1), 8'(4*k+2), 8'(4*k+3)};
        default: begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          key[k] = lfsr ^ 32'(k * 32'h9e37_79b9);
        end
      endcase
    end
    expand(nk, nw);
    @(negedge clk);
    key_ctl  = sz;
    key_word = key[0];
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      check(wr_en && busy && int'(wr_addr) == i && wr_data == w[i],
            $sformatf("%s/R8 word %0d size %0d", tag(i, nk), i, nk),
            {wr_en, busy, 22'(wr_addr), wr_data}, {2'b11, 22'(i), w[i]});
      if (i + 1 < nk) begin
        key_ctl  = 2'(i + 1);
        key_word = key[i+1];
      end else begin
        // R10: restart attempt and junk data while busy
        key_ctl  = 2'b11 - 2'(i % 3);
        key_word = 32'hdead_0000 ^ 32'(i);
      end
    end
    key_ctl = 2'b00;
    @(negedge clk);
    check(done && !busy && !wr_en, "R9 done after last word", {done, busy, wr_en}, 3'b100);
    @(negedge clk);
    check(!done && !wr_en, "R9/R10 single done, no extra write", {done, wr_en}, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    check(!wr_en && !busy && !done, "R1 in reset", {wr_en, busy, done}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr_en && !busy && !done, "R1 after reset", {wr_en, busy, done}, 3'b000);
    // R2: message code while idle starts nothing
    key_ctl  = 2'b00;
    key_word = 32'h1234_5678;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(!wr_en && !busy, "R2 message code idle", {wr_en, busy}, 2'b00);
    end
    for (int s = 1; s < 4; s++)
      for (int p = 0; p < 4; p++)
        run_key(2'(s), p);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule